// File: doc/BRIEF.md
# Shape-Selectable Single-Port Lookup RAM

This block models a pair of 16-entry, 1-bit lookup tables used as a small single-port RAM. A static parameter sets its shape. As a 16x2 memory, both tables share one 4-bit address and each stores one data bit. As a 16x1 memory, only the lower table is in use. As a 32x1 memory, the second data input becomes a fifth address bit that picks which table is read and written.

Writes are synchronous. The address, the write data and the active-high write enable are all sampled on one clock edge. A parameter chooses whether that edge is rising or falling, and the choice applies to both tables. Reads are combinational: `dout` always shows the addressed word, so it moves to the new value as soon as a write lands. A second output, `qout`, can pass the read word through a flip-flop. That flip-flop clocks on the same edge as the write or on the opposite edge, and it clears when reset is asserted. When the flip-flop is left out, `qout` simply repeats `dout`.

Top module: `dist_ram_cell`

## Requirements
- R1: With SHAPE=0 (16x2), a write with `we`=1 stores `din0` at `addr` in the lower table and `din1` at `addr` in the upper table, and `dout[0]`/`dout[1]` combinationally show the lower/upper bits at `addr`.
- R2: With SHAPE=2 (32x1), `din1` acts as address bit 4 (0 = lower table, 1 = upper table), `din0` is the only write data, `dout[0]` shows the bit at {`din1`,`addr`}, and `dout[1]` reads 0.
- R3: A write-clock edge at which `we` is 0 changes no stored bit.
- R4: With SHAPE=2, a write with `din1`=0 leaves every upper-table bit unchanged, and a write with `din1`=1 leaves every lower-table bit unchanged.
- R5: With WR_FALL=0, writes take effect on the rising edge of `clk`; with WR_FALL=1 they take effect on the falling edge, for both tables.
- R6: After a write to the location currently addressed, `dout` shows the new value right after that write edge, with no further clock.
- R7: With OUT_REG=1, `qout` takes the value `dout` had just before each capture edge, which is the write edge when OUT_OPP=0 and the other edge when OUT_OPP=1. `qout` is 0 while `rst_n` is low. With OUT_REG=0, `qout` equals `dout`.
- R8: With SHAPE=1 (16x1), `din0` is written at `addr`, `din1` has no effect, `dout[0]` shows the stored bit and `dout[1]` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for writes and for the output register |
| rst_n | input | 1 | Active-low asynchronous clear of the output register |
| we | input | 1 | Write enable, active high |
| addr | input | AW | Word address within a table |
| din0 | input | 1 | Write data for the lower table, or the only write data in 32x1 |
| din1 | input | 1 | Upper-table write data in 16x2, address bit 4 in 32x1, unused in 16x1 |
| dout | output | 2 | Combinational read word |
| qout | output | 2 | Registered read word, or a copy of `dout` |

## Verification
Some properties are checked at every write edge. A write must appear on `dout` while the address is held. An idle edge must leave the read word unchanged. A 32x1 write must leave the other table intact, and the register must hold what `dout` showed at the previous capture edge. Three other behaviours appear only in the bench's scenarios, because they depend on when a change shows up rather than on a relation between two edges. These are the half-cycle offset between rising-edge and falling-edge writes, the `dout` update seen just after an edge, and the cleared register during reset. The bench drives three shapes side by side from one stimulus stream and compares each against its own behavioural memory model.

// File: rtl/dist_ram_cell.sv
`timescale 1ns/1ps
module dist_ram_cell #(
  parameter int AW      = 4,
  parameter int SHAPE   = 0,
  parameter bit WR_FALL = 1'b0,
  parameter bit OUT_REG = 1'b1,
  parameter bit OUT_OPP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          din0,
  input  logic          din1,
  output logic [1:0]    dout,
  output logic [1:0]    qout
);
  localparam int DEPTH = 1 << AW;
  localparam bit WIDE  = (SHAPE == 0);
  localparam bit TALL  = (SHAPE == 2);

  logic [DEPTH-1:0] lo_mem, hi_mem;
  logic wclk, rclk, up_sel, lo_we, hi_we, hi_d, rd_lo, rd_hi;

  assign wclk   = clk ^ WR_FALL;
  assign rclk   = clk ^ (WR_FALL ^ OUT_OPP);
  assign up_sel = TALL & din1;
  assign lo_we  = we & ~up_sel;
  assign hi_we  = we & (WIDE | up_sel);
  assign hi_d   = TALL ? din0 : din1;

  always_ff @(posedge wclk) begin
    if (lo_we) lo_mem[addr] <= din0;
    if (hi_we) hi_mem[addr] <= hi_d;
  end

  assign rd_lo = lo_mem[addr];
  assign rd_hi = hi_mem[addr];
  assign dout  = WIDE ? {rd_hi, rd_lo} : {1'b0, up_sel ? rd_hi : rd_lo};

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) qout <= 2'b00;
        else        qout <= dout;
      end
      AST_QOUT_TRACKS: assert property (@(posedge rclk) disable iff (!rst_n)
        rst_n |=> qout == $past(dout)); // R7
    end else begin : g_ocomb
      assign qout = dout;
    end
  endgenerate

  AST_WRITE_LANDS: assert property (@(posedge wclk) disable iff (!rst_n)
    we |=> (addr != $past(addr) || din1 != $past(din1) || dout[0] == $past(din0))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge wclk) disable iff (!rst_n)
    !we |=> (addr != $past(addr) || din1 != $past(din1) || dout == $past(dout))); // R3

  generate
    if (WIDE) begin : g_wide_chk
      AST_WRITE_LANDS_HI: assert property (@(posedge wclk) disable iff (!rst_n)
        we |=> (addr != $past(addr) || dout[1] == $past(din1))); // R1
    end
    if (TALL) begin : g_tall_chk
      AST_UPPER_KEPT: assert property (@(posedge wclk) disable iff (!rst_n)
        (we && !din1) |=> hi_mem == $past(hi_mem)); // R4
      AST_LOWER_KEPT: assert property (@(posedge wclk) disable iff (!rst_n)
        (we && din1) |=> lo_mem == $past(lo_mem)); // R4
    end
  endgenerate
endmodule

// File: tb/dist_ram_cell_bench.sv
`timescale 1ns/1ps
module dist_ram_cell_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic din0 = 1'b0, din1 = 1'b0;
  logic [1:0] dout_a, qout_a, dout_b, qout_b, dout_c, qout_c;
  int checks = 0, errors = 0;
  bit ready = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  dist_ram_cell #(.AW(4), .SHAPE(2), .WR_FALL(1'b0), .OUT_REG(1'b1), .OUT_OPP(1'b0)) u_dist_ram_cell (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .din0(din0), .din1(din1), .dout(dout_a), .qout(qout_a));
  dist_ram_cell #(.AW(4), .SHAPE(0), .WR_FALL(1'b1), .OUT_REG(1'b1), .OUT_OPP(1'b1)) u_dist_ram_cell_w (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .din0(din0), .din1(din1), .dout(dout_b), .qout(qout_b));
  dist_ram_cell #(.AW(4), .SHAPE(1), .WR_FALL(1'b0), .OUT_REG(1'b0), .OUT_OPP(1'b0)) u_dist_ram_cell_n (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .din0(din0), .din1(din1), .dout(dout_c), .qout(qout_c));

  logic [31:0] ma;
  logic [1:0]  mb [16];
  logic [15:0] mc;
  logic qa;
  logic [1:0] qb;

  always @(posedge clk) begin
    if (!rst_n) qa = 1'b0; else qa = ma[{din1, addr}];
    if (we) ma[{din1, addr}] = din0;
    if (we) mc[addr] = din0;
    if (!rst_n) qb = 2'b00; else qb = mb[addr];
  end
  always @(negedge clk) if (we) mb[addr] = {din1, din0};
  always @(negedge rst_n) begin qa = 1'b0; qb = 2'b00; end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 32x1 dout", dout_a, {1'b0, ma[{din1, addr}]});
    chk("R7 32x1 qout same edge", qout_a, {1'b0, qa});
    chk("R1 R5 16x2 falling-edge dout", dout_b, mb[addr]);
    chk("R7 16x2 qout opposite edge", qout_b, qb);
    chk("R8 16x1 dout", dout_c, {1'b0, mc[addr]});
    chk("R7 16x1 unregistered qout", qout_c, {1'b0, mc[addr]});
  endtask

  task automatic cyc(input logic w, input logic [3:0] a, input logic d0, input logic d1);
    @(posedge clk);
    #1 we = w; addr = a; din0 = d0; din1 = d1;
    #3 if (ready) compare_all();
  endtask

  initial begin
    logic old_bit, keep_bit, nv;
    repeat (3) begin
      @(posedge clk); #4;
      chk("R7 reset qout 32x1", qout_a, 2'b00);
      chk("R7 reset qout 16x2", qout_b, 2'b00);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 32; i++) cyc(1'b1, i[3:0], i[0] ^ i[2], i[4] ^ i[1]);
    cyc(1'b0, 4'd0, 1'b0, 1'b0);
    ready = 1'b1;
    for (int i = 0; i < 32; i++) cyc(1'b0, i[3:0], 1'b1, i[4]);

    // R6: new value visible just after the write edge
    nv = ~ma[{1'b1, 4'd5}];
    cyc(1'b1, 4'd5, nv, 1'b1);
    #1.5 chk("R6 32x1 dout right after write edge", dout_a, {1'b0, nv});
    cyc(1'b0, 4'd5, nv, 1'b1);

    // R5: the falling-edge instance shows data half a cycle earlier
    nv = ~mb[9][0];
    cyc(1'b1, 4'd9, nv, 1'b0);
    chk("R5 falling-edge write already visible", {1'b0, dout_b[0]}, {1'b0, nv});
    cyc(1'b0, 4'd9, 1'b0, 1'b0);

    // R3: write enable low leaves the location unchanged
    old_bit = ma[{1'b0, 4'd7}];
    cyc(1'b0, 4'd7, ~old_bit, 1'b0);
    cyc(1'b0, 4'd7, ~old_bit, 1'b0);
    chk("R3 no write when we low", dout_a, {1'b0, old_bit});

    // R4: lower-half write keeps the upper location with the same index
    keep_bit = ma[{1'b1, 4'd2}];
    cyc(1'b1, 4'd2, ~ma[{1'b0, 4'd2}], 1'b0);
    cyc(1'b0, 4'd2, 1'b0, 1'b1);
    chk("R4 upper half untouched", dout_a, {1'b0, keep_bit});
    keep_bit = ma[{1'b0, 4'd11}];
    cyc(1'b1, 4'd11, ~ma[{1'b1, 4'd11}], 1'b1);
    cyc(1'b0, 4'd11, 1'b0, 1'b0);
    chk("R4 lower half untouched", dout_a, {1'b0, keep_bit});

    for (int i = 0; i < 300; i++)
      cyc(1'(($urandom % 3) == 0), 4'($urandom), 1'($urandom), 1'($urandom));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule